// File: doc/BRIEF.md
# Pipelined Vector-to-Polar Converter with Reference Normalisation

This block takes one signed I/Q sample per clock and produces its magnitude and phase using an angle-accumulating CORDIC in vectoring mode. First, a quarter-turn pre-rotation moves any sample with a negative in-phase part into the right half-plane. Sixteen shift-and-add micro-rotations then drive the quadrature part to zero while summing the applied angles. A fixed multiply removes the CORDIC gain.

A second pipeline stage expresses the result relative to a reference channel. The magnitude becomes an unsigned 16-bit fraction of the reference magnitude, computed by a restoring divider with one quotient bit per stage. The phase becomes the difference from the reference phase, in wrapping binary-angle arithmetic.

A marker bit enters with each sample and leaves with that sample's results, so a downstream consumer knows which output words carry data. The reference magnitude and phase for a sample are presented in the same cycle as its I/Q pair and travel down the pipeline with it. A typical source for the reference pair is a sibling converter serving the reference channel. All outputs of a sample appear together, 34 cycles after its input.

Top module: `polar_norm_unit`

## Requirements
- R1: `mag_o` is an unsigned 16-bit magnitude within 3 LSB of sqrt(I^2+Q^2), for every signed 16-bit input pair, including (-32768,-32768).
- R2: `phase_o` is a signed 16-bit binary angle in which 32768 steps make a half turn (value 16384 is +90 degrees, -32768 is -180 degrees). Its error is at most 4 LSB (modulo 65536) from atan2(Q,I) in all four quadrants, whenever the true magnitude is 512 or more.
- R3: A new sample is accepted every clock. Its `mag_o`, `phase_o`, `norm_mag_o` and `norm_phase_o` appear together exactly 34 cycles after the cycle in which it was presented.
- R4: `mark_o` equals `mark_i` delayed by exactly 34 cycles, and flags exactly the cycles whose outputs belong to a marked sample.
- R5: Reset is synchronous and active high. It clears the marker pipeline: markers presented while reset is high never emerge, and `mark_o` stays low after reset until marked samples have crossed the full pipeline.
- R6: When `mag_o` is less than the sample's reference magnitude R, `norm_mag_o` equals floor(`mag_o` * 65536 / R).
- R7: When `mag_o` is greater than or equal to R, including R = 0, `norm_mag_o` saturates to 16'hFFFF.
- R8: `norm_phase_o` equals `phase_o` minus the sample's reference phase, modulo 65536, so a difference beyond half a turn wraps to the opposite sign.
- R9: The reference pair used for a sample is the one presented in that sample's own input cycle, even when the reference changes every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_in | input | 16 | In-phase sample, signed |
| q_in | input | 16 | Quadrature sample, signed |
| mark_i | input | 1 | Marker travelling with the sample |
| ref_mag_i | input | 16 | Reference magnitude for this sample, unsigned |
| ref_phase_i | input | 16 | Reference phase for this sample, binary angle |
| mag_o | output | 16 | Magnitude, unsigned |
| phase_o | output | 16 | Phase, binary angle |
| norm_mag_o | output | 16 | Magnitude as a fraction of the reference, saturating |
| norm_phase_o | output | 16 | Phase relative to the reference, wrapping |
| mark_o | output | 1 | Marker aligned with all outputs |

## Verification
The embedded assertions check structural invariants on every cycle:
- after pre-rotation the X path is never negative, and each micro-rotation never shrinks it;
- the quadrature residue at the end of the iterations is small;
- every divider remainder stays below its divisor;
- the magnitude never exceeds the largest reachable value;
- reset removes any pending marker.

Numerical accuracy against atan2 and the square root, the exact 34-cycle alignment of marker and data, the quotient values, saturation at equality and at a zero reference, and phase wrap-around are visible only in the bench scenarios, which compare every marked output against values computed in the bench.

// File: rtl/polar_pkg.sv
package polar_pkg;
    localparam int IW    = 16;            // sample and result width
    localparam int GUARD = 6;             // extra fraction bits on X/Y
    localparam int XW    = IW + GUARD + 4; // X/Y datapath width
    localparam int ZW    = IW + 4;        // angle accumulator width, full scale = one turn
    localparam int ITERS = 16;            // micro-rotations (angle table holds 16)
    localparam int KW    = 16;            // gain constant width
    localparam logic [KW-1:0] KGAIN = 16'd39797; // round(0.6072529 * 2^16)
    localparam int LATENCY = 1 + ITERS + 1 + IW;

    typedef struct packed {
        logic                 mark;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
        logic [IW-1:0]        rmag;
        logic [IW-1:0]        rph;
    } vec_t;

    typedef struct packed {
        logic          mark;
        logic [IW-1:0] mag;
        logic [IW-1:0] ph;
        logic [IW-1:0] rmag;
        logic [IW-1:0] rph;
    } pol_t;

    typedef struct packed {
        logic          mark;
        logic          sat;
        logic [IW-1:0] mag;
        logic [IW-1:0] ph;
        logic [IW-1:0] nph;
        logic [IW-1:0] rmag;
        logic [IW-1:0] rem;
        logic [IW-1:0] quo;
    } div_t;

    // arctan(2^-k) in units of one turn / 2^ZW, rounded
    function automatic logic signed [ZW-1:0] atan_step(input int k);
        case (k)
            0:       return 20'sd131072;
            1:       return 20'sd77376;
            2:       return 20'sd40884;
            3:       return 20'sd20753;
            4:       return 20'sd10417;
            5:       return 20'sd5213;
            6:       return 20'sd2607;
            7:       return 20'sd1304;
            8:       return 20'sd652;
            9:       return 20'sd326;
            10:      return 20'sd163;
            11:      return 20'sd81;
            12:      return 20'sd41;
            13:      return 20'sd20;
            14:      return 20'sd10;
            15:      return 20'sd5;
            default: return 20'sd0;
        endcase
    endfunction
endpackage

// File: rtl/iq_prerotate.sv
module iq_prerotate
    import polar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [IW-1:0] i_in,
    input  logic signed [IW-1:0] q_in,
    input  logic                 mark_in,
    input  logic [IW-1:0]        rmag_in,
    input  logic [IW-1:0]        rph_in,
    output vec_t                 st_o
);
    localparam logic signed [ZW-1:0] QUARTER = ZW'(1) <<< (ZW - 2);

    vec_t st_d, st_q;
    logic signed [XW-1:0] ie, qe;

    always_comb begin
        ie = $signed({{(XW-IW-GUARD){i_in[IW-1]}}, i_in, {GUARD{1'b0}}});
        qe = $signed({{(XW-IW-GUARD){q_in[IW-1]}}, q_in, {GUARD{1'b0}}});
        st_d      = '0;
        st_d.mark = mark_in;
        st_d.rmag = rmag_in;
        st_d.rph  = rph_in;
        if (!i_in[IW-1]) begin
            st_d.x = ie;
            st_d.y = qe;
            st_d.z = '0;
        end else if (!q_in[IW-1]) begin
            st_d.x = qe;          // turn back by a quarter
            st_d.y = -ie;
            st_d.z = QUARTER;
        end else begin
            st_d.x = -qe;         // turn forward by a quarter
            st_d.y = ie;
            st_d.z = -QUARTER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;

    AST_PRE_RIGHT_HALF: assert property (@(posedge clk) disable iff (rst)
        st_q.mark |-> st_q.x >= 0); // R2
endmodule

// File: rtl/cordic_micro.sv
module cordic_micro
    import polar_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic clk,
    input  logic rst,
    input  vec_t st_i,
    output vec_t st_o
);
    localparam logic signed [ZW-1:0] ANGLE = atan_step(SHIFT);

    vec_t st_d, st_q;
    logic signed [XW-1:0] xs, ys;

    always_comb begin
        xs   = st_i.x >>> SHIFT;
        ys   = st_i.y >>> SHIFT;
        st_d = st_i;
        if (st_i.y[XW-1]) begin
            st_d.x = st_i.x - ys;
            st_d.y = st_i.y + xs;
            st_d.z = st_i.z - ANGLE;
        end else begin
            st_d.x = st_i.x + ys;
            st_d.y = st_i.y - xs;
            st_d.z = st_i.z + ANGLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;

    AST_X_NONDECREASING: assert property (@(posedge clk) disable iff (rst)
        st_q.mark |-> st_q.x >= $past(st_i.x)); // R1
endmodule

// File: rtl/mag_scale.sv
module mag_scale
    import polar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t st_i,
    output pol_t st_o
);
    localparam int PW  = XW + KW;
    localparam int RSH = KW + GUARD;
    localparam logic [PW-1:0] HALF = PW'(1) << (RSH - 1);
    localparam logic signed [ZW-1:0] ZHALF = ZW'(1) <<< (ZW - IW - 1);

    pol_t st_d, st_q;
    logic [XW-1:0]        xu;
    logic [PW-1:0]        prod, scaled;
    logic signed [ZW-1:0] zr;

    always_comb begin
        xu     = st_i.x;
        prod   = {{KW{1'b0}}, xu} * {{XW{1'b0}}, KGAIN};
        scaled = (prod + HALF) >> RSH;
        zr     = st_i.z + ZHALF;
        st_d.mark = st_i.mark;
        st_d.rmag = st_i.rmag;
        st_d.rph  = st_i.rph;
        st_d.ph   = zr[ZW-1:ZW-IW];
        st_d.mag  = (|scaled[PW-1:IW]) ? '1 : scaled[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;

    AST_Y_CONVERGED: assert property (@(posedge clk) disable iff (rst)
        st_i.mark |-> (st_i.y <= (st_i.x >>> 12) + 64) && (st_i.y >= -((st_i.x >>> 12) + 64))); // R2
endmodule

// File: rtl/ratio_step.sv
module ratio_step
    import polar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  div_t st_i,
    output div_t st_o
);
    div_t st_d, st_q;
    logic [IW:0] r2;

    always_comb begin
        r2   = {st_i.rem, 1'b0};
        st_d = st_i;
        if (r2 >= {1'b0, st_i.rmag}) begin
            st_d.rem = IW'(r2 - {1'b0, st_i.rmag});
            st_d.quo = {st_i.quo[IW-2:0], 1'b1};
        end else begin
            st_d.rem = r2[IW-1:0];
            st_d.quo = {st_i.quo[IW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (st_q.mark && !st_q.sat) |-> st_q.rem < st_q.rmag); // R6
endmodule

// File: rtl/polar_norm_unit.sv
module polar_norm_unit
    import polar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [IW-1:0] i_in,
    input  logic signed [IW-1:0] q_in,
    input  logic                 mark_i,
    input  logic [IW-1:0]        ref_mag_i,
    input  logic [IW-1:0]        ref_phase_i,
    output logic [IW-1:0]        mag_o,
    output logic [IW-1:0]        phase_o,
    output logic [IW-1:0]        norm_mag_o,
    output logic [IW-1:0]        norm_phase_o,
    output logic                 mark_o
);
    vec_t vec_s [ITERS+1];
    pol_t pol_s;
    div_t div_head;
    div_t div_s [IW];

    iq_prerotate u_pre (
        .clk(clk), .rst(rst), .i_in(i_in), .q_in(q_in), .mark_in(mark_i),
        .rmag_in(ref_mag_i), .rph_in(ref_phase_i), .st_o(vec_s[0])
    );

    for (genvar g = 0; g < ITERS; g++) begin : g_iter
        cordic_micro #(.SHIFT(g)) u_micro (
            .clk(clk), .rst(rst), .st_i(vec_s[g]), .st_o(vec_s[g+1])
        );
    end

    mag_scale u_scale (
        .clk(clk), .rst(rst), .st_i(vec_s[ITERS]), .st_o(pol_s)
    );

    always_comb begin
        div_head.mark = pol_s.mark;
        div_head.mag  = pol_s.mag;
        div_head.ph   = pol_s.ph;
        div_head.nph  = pol_s.ph - pol_s.rph;
        div_head.rmag = pol_s.rmag;
        div_head.sat  = pol_s.mag >= pol_s.rmag;
        div_head.rem  = pol_s.mag;
        div_head.quo  = '0;
    end

    for (genvar g = 0; g < IW; g++) begin : g_div
        if (g == 0) begin : g_first
            ratio_step u_step (.clk(clk), .rst(rst), .st_i(div_head), .st_o(div_s[g]));
        end else begin : g_next
            ratio_step u_step (.clk(clk), .rst(rst), .st_i(div_s[g-1]), .st_o(div_s[g]));
        end
    end

    assign mark_o       = div_s[IW-1].mark;
    assign mag_o        = div_s[IW-1].mag;
    assign phase_o      = div_s[IW-1].ph;
    assign norm_phase_o = div_s[IW-1].nph;
    assign norm_mag_o   = div_s[IW-1].sat ? '1 : div_s[IW-1].quo;

    AST_RST_CLEARS_MARK: assert property (@(posedge clk)
        rst |=> !mark_o); // R5

    AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> mag_o <= 16'd46345); // R1

    AST_FINAL_REMAINDER: assert property (@(posedge clk) disable iff (rst)
        (mark_o && !div_s[IW-1].sat) |-> div_s[IW-1].rem < div_s[IW-1].rmag); // R6
endmodule

// File: tb/polar_norm_unit_bench.sv
module polar_norm_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 34;
    localparam int NS  = 3000;
    localparam int ND  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] i_in = '0, q_in = '0;
    logic mark_i = 1'b0;
    logic [15:0] ref_mag_i = '0, ref_phase_i = '0;
    logic [15:0] mag_o, phase_o, norm_mag_o, norm_phase_o;
    logic mark_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic signed [15:0] si [NS];
    logic signed [15:0] sq [NS];
    logic [15:0] srm [NS];
    logic [15:0] srp [NS];
    logic        sm  [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    polar_norm_unit u_polar_norm_unit (
        .clk(clk), .rst(rst), .i_in(i_in), .q_in(q_in), .mark_i(mark_i),
        .ref_mag_i(ref_mag_i), .ref_phase_i(ref_phase_i),
        .mag_o(mag_o), .phase_o(phase_o), .norm_mag_o(norm_mag_o),
        .norm_phase_o(norm_phase_o), .mark_o(mark_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real true_mag(input int a, input int b);
        return $sqrt(real'(a) * real'(a) + real'(b) * real'(b));
    endfunction

    function automatic logic [15:0] exp_phase(input int a, input int b);
        real r;
        int e;
        r = $atan2(real'(b), real'(a)) * 32768.0 / 3.14159265358979;
        e = (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
        return e[15:0];
    endfunction

    function automatic logic [15:0] exp_ratio(input logic [15:0] m, input logic [15:0] r);
        longint qv;
        if (m >= r) return 16'hFFFF;
        qv = (longint'(m) << 16) / longint'(r);
        return qv[15:0];
    endfunction

    task automatic check_sample(input int j);
        int a, b, dm, dp;
        real tm;
        logic [15:0] ep, en, enp;
        logic signed [15:0] pd;
        chk(mark_o == sm[j], "R4 marker alignment", mark_o, sm[j]);
        if (sm[j]) begin
            a  = si[j];
            b  = sq[j];
            tm = true_mag(a, b);
            dm = int'(mag_o) - $rtoi(tm + 0.5);
            chk(dm <= 3 && dm >= -3, "R1 magnitude", mag_o, $rtoi(tm + 0.5));
            if (tm >= 512.0) begin
                ep = exp_phase(a, b);
                pd = phase_o - ep;
                dp = pd;
                chk(dp <= 4 && dp >= -4, "R2 phase", phase_o, ep);
            end
            en = exp_ratio(mag_o, srm[j]);
            chk(norm_mag_o == en, (mag_o >= srm[j]) ? "R7 saturation" : "R6 ratio R3 R9",
                norm_mag_o, en);
            enp = phase_o - srp[j];
            chk(norm_phase_o == enp, "R8 relative phase R9", norm_phase_o, enp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed corners
        si[0]  = 16'sd32767;  sq[0]  = 16'sd0;      srm[0]  = 16'd65535; srp[0]  = 16'h8000;
        si[1]  = -16'sd32768; sq[1]  = 16'sd0;      srm[1]  = 16'd40000; srp[1]  = 16'h7FFF;
        si[2]  = 16'sd0;      sq[2]  = 16'sd32767;  srm[2]  = 16'd1;     srp[2]  = 16'hC000;
        si[3]  = 16'sd0;      sq[3]  = -16'sd32768; srm[3]  = 16'd50000; srp[3]  = 16'h4001;
        si[4]  = -16'sd32768; sq[4]  = -16'sd32768; srm[4]  = 16'd65535; srp[4]  = 16'h0000;
        si[5]  = 16'sd32767;  sq[5]  = 16'sd32767;  srm[5]  = 16'd46341; srp[5]  = 16'h2000;
        si[6]  = -16'sd20000; sq[6]  = 16'sd1;      srm[6]  = 16'd30000; srp[6]  = 16'h9000;
        si[7]  = -16'sd20000; sq[7]  = -16'sd1;     srm[7]  = 16'd30000; srp[7]  = 16'h7000;
        si[8]  = 16'sd1000;   sq[8]  = 16'sd0;      srm[8]  = 16'd1000;  srp[8]  = 16'h0001;
        si[9]  = 16'sd0;      sq[9]  = 16'sd0;      srm[9]  = 16'd0;     srp[9]  = 16'hFFFF;
        si[10] = 16'sd3000;   sq[10] = -16'sd4000;  srm[10] = 16'd5000;  srp[10] = 16'h1234;
        si[11] = 16'sd300;    sq[11] = 16'sd400;    srm[11] = 16'd65535; srp[11] = 16'h8001;
        for (int n = 0; n < ND; n++) sm[n] = 1'b1;
        for (int n = ND; n < NS; n++) begin
            si[n]  = $urandom() & 16'hFFFF;
            sq[n]  = $urandom() & 16'hFFFF;
            srm[n] = ($urandom() % 4 == 0) ? 16'($urandom() & 16'h0FFF) : 16'($urandom() & 16'hFFFF);
            srp[n] = $urandom() & 16'hFFFF;
            sm[n]  = ($urandom() % 4) != 0;
        end

        // reset phase: stale markers offered while reset is high
        rst = 1'b1;
        mark_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(mark_o == 1'b0, "R5 reset marker", mark_o, 0);
        chk(mag_o == 16'd0, "R5 reset magnitude", mag_o, 0);

        for (int k = 0; k < NS + LAT; k++) begin
            @(negedge clk);
            rst = 1'b0;
            if (k >= LAT) check_sample(k - LAT);
            else chk(mark_o == 1'b0, "R5 no marker after reset", mark_o, 0);
            if (k < NS) begin
                i_in = si[k]; q_in = sq[k]; ref_mag_i = srm[k];
                ref_phase_i = srp[k]; mark_i = sm[k];
            end else begin
                mark_i = 1'b0;
            end
        end
        @(negedge clk);
        chk(mark_o == 1'b0, "R4 marker after drain", mark_o, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule